// File: doc/BRIEF.md
# Micro-coded GEMM accumulate core

This block is the arithmetic heart of a small dense linear-algebra engine. A command names a run of micro-ops in a local micro-op RAM by start address and length. The core walks that run at one micro-op per clock. Each micro-op word splits into three row indices: a destination row of the accumulator RAM, a source row of the input RAM and a row of the weight RAM. For every micro-op the block multiplies a BATCH x BLOCK_IN signed 8-bit input tile by a BLOCK_OUT x BLOCK_IN signed 8-bit weight tile. The weight tile is stored transposed, so each output column uses one weight row. The BATCH x BLOCK_OUT product is added into the 32-bit destination row.

The accumulator update is a read-modify-write pipeline with no forwarding and no stall. A row written in one cycle can be read back correctly by the micro-op two places behind the writer, but not by the micro-op right behind it. Micro-op programs must therefore never put two adjacent micro-ops on the same destination row. A debug flag marks every place where a program breaks this rule. A clear mode writes zero to every addressed row instead of accumulating. The input, weight and micro-op RAMs are filled through simple write ports. Accumulator rows are read out through a read port while the core is idle.

Top module: `gemm_uop_core`

## Requirements
- R1: A micro-op word holds the destination row in bits [ACC_AW-1:0], the input row in the next INP_AW bits and the weight row in the WGT_AW bits above those.
- R2: Packing of tile elements:
  - Input element (b,k) sits at bits [(b*BLOCK_IN+k)*8 +: 8] of an input row.
  - Weight element (o,k) sits at bits [(o*BLOCK_IN+k)*8 +: 8] of a weight row.
  - Accumulator element (b,o) sits at bits [(b*BLOCK_OUT+o)*32 +: 32] of an accumulator row.
- R3: In accumulate mode each micro-op sets acc[dst](b,o) to acc[dst](b,o) + sum over k of inp[src](b,k)*wgt[w](o,k). Operands are two's complement and the sum wraps modulo 2^32.
- R4: When clear_mode_i is high on the accepted start, every micro-op of that command writes zero to its destination row.
- R5: A start with nonzero count seen while busy_o is low is accepted. busy_o is then high for exactly count cycles, and one micro-op is issued per cycle from consecutive addresses, wrapping at the RAM depth.
- R6: done_o is high for exactly one cycle. If the start is sampled at clock edge 0, done_o rises at edge count+2.
- R7: When two adjacent micro-ops share a destination row, the second one reads the row value from before the first one's write. The first update is lost. A micro-op two places later sees the update.
- R8: hazard_o is high for one cycle for each pair of adjacent micro-ops with equal destination rows, and is low otherwise.
- R9: A start seen while busy_o is high is ignored. A start with count zero is ignored: busy_o stays low and no done_o follows.
- R10: While rst_ni is low and in the first cycle after reset, busy_o, done_o and hazard_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command strobe |
| clear_mode_i | input | 1 | Command writes zeros instead of accumulating |
| base_i | input | UOP_AW | First micro-op address |
| count_i | input | COUNT_W | Number of micro-ops |
| busy_o | output | 1 | Micro-ops still being issued |
| done_o | output | 1 | One-cycle pulse after the last row write |
| hazard_o | output | 1 | Adjacent micro-ops share a destination row |
| uop_we_i | input | 1 | Micro-op RAM write enable |
| uop_waddr_i | input | UOP_AW | Micro-op RAM write address |
| uop_wdata_i | input | UOP_W | Micro-op word |
| inp_we_i | input | 1 | Input RAM write enable |
| inp_waddr_i | input | INP_AW | Input RAM write address |
| inp_wdata_i | input | INP_ROW_W | Input tile row |
| wgt_we_i | input | 1 | Weight RAM write enable |
| wgt_waddr_i | input | WGT_AW | Weight RAM write address |
| wgt_wdata_i | input | WGT_ROW_W | Transposed weight tile row |
| acc_raddr_i | input | ACC_AW | Accumulator read address while idle |
| acc_rdata_o | output | ACC_ROW_W | Accumulator row, one cycle after the address |

## Verification
The checker watches the command handshake on every cycle:
- a start accepted while idle raises busy_o;
- a zero-count start leaves the core idle;
- done_o lasts one cycle and is always preceded by issue activity;
- hazard_o only appears while micro-ops are flowing.

The arithmetic, the element packing, the clear mode, the exact done latency and the lost update on adjacent equal destinations need data. Only the bench scenarios can show these. They read accumulator rows back and compare them against a reference model that reproduces the stale read.

// File: rtl/gemm_uop_pkg.sv
package gemm_uop_pkg;
  localparam int DATA_W = 8;
  localparam int ACC_W  = 32;

  typedef struct packed {
    logic vld;
    logic last;
    logic clr;
  } stage_ctl_t;
endpackage

// File: rtl/gemm_sram.sv
module gemm_sram #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  // read returns the old word on a same-edge write
  always_ff @(posedge clk_i) begin
    rdata_o <= mem_q[raddr_i];
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end
endmodule

// File: rtl/gemm_uop_seq.sv
module gemm_uop_seq
  import gemm_uop_pkg::*;
#(
  parameter int UOP_AW  = 6,
  parameter int COUNT_W = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               clear_mode_i,
  input  logic [UOP_AW-1:0]  base_i,
  input  logic [COUNT_W-1:0] count_i,
  output logic               busy_o,
  output logic [UOP_AW-1:0]  rd_addr_o,
  output stage_ctl_t         issue_o
);
  logic               busy_q, clr_q;
  logic [UOP_AW-1:0]  pc_q;
  logic [COUNT_W-1:0] rem_q;
  logic               last_w;

  assign last_w = (rem_q == COUNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      clr_q  <= 1'b0;
      pc_q   <= '0;
      rem_q  <= '0;
    end else if (busy_q) begin
      pc_q   <= pc_q + UOP_AW'(1);
      rem_q  <= rem_q - COUNT_W'(1);
      busy_q <= !last_w;
    end else if (start_i && (count_i != '0)) begin
      busy_q <= 1'b1;
      clr_q  <= clear_mode_i;
      pc_q   <= base_i;
      rem_q  <= count_i;
    end
  end

  assign busy_o       = busy_q;
  assign rd_addr_o    = pc_q;
  assign issue_o.vld  = busy_q;
  assign issue_o.last = busy_q && last_w;
  assign issue_o.clr  = clr_q;
endmodule

// File: rtl/gemm_mac_tile.sv
module gemm_mac_tile
  import gemm_uop_pkg::*;
#(
  parameter int BATCH     = 1,
  parameter int BLOCK_IN  = 16,
  parameter int BLOCK_OUT = 16,
  localparam int INP_ROW_W = BATCH * BLOCK_IN * DATA_W,
  localparam int WGT_ROW_W = BLOCK_OUT * BLOCK_IN * DATA_W,
  localparam int ACC_ROW_W = BATCH * BLOCK_OUT * ACC_W
) (
  input  logic [INP_ROW_W-1:0] inp_row_i,
  input  logic [WGT_ROW_W-1:0] wgt_row_i,
  input  logic [ACC_ROW_W-1:0] acc_row_i,
  output logic [ACC_ROW_W-1:0] acc_row_o
);
  for (genvar b = 0; b < BATCH; b++) begin : g_b
    for (genvar o = 0; o < BLOCK_OUT; o++) begin : g_o
      logic signed [ACC_W-1:0] sum;
      always_comb begin
        logic [DATA_W-1:0]       xa, wb;
        logic signed [ACC_W-1:0] xe, we;
        sum = $signed(acc_row_i[(b*BLOCK_OUT+o)*ACC_W +: ACC_W]);
        for (int k = 0; k < BLOCK_IN; k++) begin
          xa  = inp_row_i[(b*BLOCK_IN+k)*DATA_W +: DATA_W];
          wb  = wgt_row_i[(o*BLOCK_IN+k)*DATA_W +: DATA_W];
          xe  = $signed({{(ACC_W-DATA_W){xa[DATA_W-1]}}, xa});
          we  = $signed({{(ACC_W-DATA_W){wb[DATA_W-1]}}, wb});
          sum = sum + xe * we;
        end
      end
      assign acc_row_o[(b*BLOCK_OUT+o)*ACC_W +: ACC_W] = sum;
    end
  end
endmodule

// File: rtl/gemm_uop_core.sv
module gemm_uop_core
  import gemm_uop_pkg::*;
#(
  parameter int BATCH      = 1,
  parameter int BLOCK_IN   = 16,
  parameter int BLOCK_OUT  = 16,
  parameter int UOP_DEPTH  = 64,
  parameter int INP_DEPTH  = 32,
  parameter int WGT_DEPTH  = 32,
  parameter int ACC_DEPTH  = 32,
  localparam int UOP_AW    = $clog2(UOP_DEPTH),
  localparam int INP_AW    = $clog2(INP_DEPTH),
  localparam int WGT_AW    = $clog2(WGT_DEPTH),
  localparam int ACC_AW    = $clog2(ACC_DEPTH),
  localparam int UOP_W     = ACC_AW + INP_AW + WGT_AW,
  localparam int COUNT_W   = UOP_AW + 1,
  localparam int INP_ROW_W = BATCH * BLOCK_IN * DATA_W,
  localparam int WGT_ROW_W = BLOCK_OUT * BLOCK_IN * DATA_W,
  localparam int ACC_ROW_W = BATCH * BLOCK_OUT * ACC_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 clear_mode_i,
  input  logic [UOP_AW-1:0]    base_i,
  input  logic [COUNT_W-1:0]   count_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 hazard_o,
  input  logic                 uop_we_i,
  input  logic [UOP_AW-1:0]    uop_waddr_i,
  input  logic [UOP_W-1:0]     uop_wdata_i,
  input  logic                 inp_we_i,
  input  logic [INP_AW-1:0]    inp_waddr_i,
  input  logic [INP_ROW_W-1:0] inp_wdata_i,
  input  logic                 wgt_we_i,
  input  logic [WGT_AW-1:0]    wgt_waddr_i,
  input  logic [WGT_ROW_W-1:0] wgt_wdata_i,
  input  logic [ACC_AW-1:0]    acc_raddr_i,
  output logic [ACC_ROW_W-1:0] acc_rdata_o
);
  stage_ctl_t          issue, s1_q, s2_q;
  logic [UOP_AW-1:0]   uop_raddr;
  logic [UOP_W-1:0]    uop_word;
  logic [ACC_AW-1:0]   dst1, dst2_q, acc_raddr;
  logic [INP_AW-1:0]   src1;
  logic [WGT_AW-1:0]   wsel1;
  logic [INP_ROW_W-1:0] inp_row;
  logic [WGT_ROW_W-1:0] wgt_row;
  logic [ACC_ROW_W-1:0] acc_row, acc_sum, acc_wdata;
  logic                 done_q;

  gemm_uop_seq #(.UOP_AW(UOP_AW), .COUNT_W(COUNT_W)) u_seq (
    .clk_i, .rst_ni, .start_i, .clear_mode_i, .base_i, .count_i,
    .busy_o, .rd_addr_o(uop_raddr), .issue_o(issue)
  );

  gemm_sram #(.DEPTH(UOP_DEPTH), .WIDTH(UOP_W)) u_uop_ram (
    .clk_i, .we_i(uop_we_i), .waddr_i(uop_waddr_i), .wdata_i(uop_wdata_i),
    .raddr_i(uop_raddr), .rdata_o(uop_word)
  );

  // stage 1: decode
  assign dst1  = uop_word[ACC_AW-1:0];
  assign src1  = uop_word[ACC_AW +: INP_AW];
  assign wsel1 = uop_word[ACC_AW+INP_AW +: WGT_AW];
  assign acc_raddr = s1_q.vld ? dst1 : acc_raddr_i;

  gemm_sram #(.DEPTH(INP_DEPTH), .WIDTH(INP_ROW_W)) u_inp_ram (
    .clk_i, .we_i(inp_we_i), .waddr_i(inp_waddr_i), .wdata_i(inp_wdata_i),
    .raddr_i(src1), .rdata_o(inp_row)
  );

  gemm_sram #(.DEPTH(WGT_DEPTH), .WIDTH(WGT_ROW_W)) u_wgt_ram (
    .clk_i, .we_i(wgt_we_i), .waddr_i(wgt_waddr_i), .wdata_i(wgt_wdata_i),
    .raddr_i(wsel1), .rdata_o(wgt_row)
  );

  // stage 2: multiply-accumulate and write back, no bypass
  gemm_mac_tile #(.BATCH(BATCH), .BLOCK_IN(BLOCK_IN), .BLOCK_OUT(BLOCK_OUT)) u_mac (
    .inp_row_i(inp_row), .wgt_row_i(wgt_row), .acc_row_i(acc_row), .acc_row_o(acc_sum)
  );

  assign acc_wdata = s2_q.clr ? '0 : acc_sum;

  gemm_sram #(.DEPTH(ACC_DEPTH), .WIDTH(ACC_ROW_W)) u_acc_ram (
    .clk_i, .we_i(s2_q.vld), .waddr_i(dst2_q), .wdata_i(acc_wdata),
    .raddr_i(acc_raddr), .rdata_o(acc_row)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      dst2_q <= '0;
      done_q <= 1'b0;
    end else begin
      s1_q   <= issue;
      s2_q   <= s1_q;
      dst2_q <= dst1;
      done_q <= s2_q.vld && s2_q.last;
    end
  end

  assign done_o      = done_q;
  assign hazard_o    = s1_q.vld && s2_q.vld && (dst1 == dst2_q);
  assign acc_rdata_o = acc_row;
endmodule

// File: rtl/gemm_uop_core_chk.sv
module gemm_uop_core_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic count_zero_i,
  input logic busy_o,
  input logic done_o,
  input logic hazard_o
);
  p_start_accept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && !count_zero_i) |=> busy_o);

  p_zero_count_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && count_zero_i) |=> !busy_o);

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_after_issue_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o, 3));

  p_hazard_in_flow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hazard_o |-> $past(busy_o));

  always_comb begin
    if (!rst_ni) begin
      a_reset_idle_r10: assert (!busy_o && !done_o && !hazard_o);
    end
  end
endmodule

bind gemm_uop_core gemm_uop_core_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .count_zero_i(count_i == '0),
  .busy_o(busy_o), .done_o(done_o), .hazard_o(hazard_o)
);

// File: tb/gemm_uop_core_test.sv
module gemm_uop_core_test;
  localparam int BI = 16, BO = 16, NB = 1;
  localparam int UD = 64, ID = 32, WD = 32, AD = 32;
  localparam int UAW = 6, IAW = 5, WAW = 5, AAW = 5;
  localparam int UW = AAW + IAW + WAW, CW = UAW + 1;
  localparam int IRW = NB*BI*8, WRW = BO*BI*8, ARW = NB*BO*32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, clr_mode = 0;
  logic [UAW-1:0] base_r = '0;
  logic [CW-1:0]  count_r = '0;
  logic busy, done, haz;
  logic uop_we = 0; logic [UAW-1:0] uop_wa = '0; logic [UW-1:0] uop_wd = '0;
  logic inp_we = 0; logic [IAW-1:0] inp_wa = '0; logic [IRW-1:0] inp_wd = '0;
  logic wgt_we = 0; logic [WAW-1:0] wgt_wa = '0; logic [WRW-1:0] wgt_wd = '0;
  logic [AAW-1:0] acc_ra = '0;
  logic [ARW-1:0] acc_rd;

  gemm_uop_core uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .clear_mode_i(clr_mode),
    .base_i(base_r), .count_i(count_r), .busy_o(busy), .done_o(done), .hazard_o(haz),
    .uop_we_i(uop_we), .uop_waddr_i(uop_wa), .uop_wdata_i(uop_wd),
    .inp_we_i(inp_we), .inp_waddr_i(inp_wa), .inp_wdata_i(inp_wd),
    .wgt_we_i(wgt_we), .wgt_waddr_i(wgt_wa), .wgt_wdata_i(wgt_wd),
    .acc_raddr_i(acc_ra), .acc_rdata_o(acc_rd)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  logic [IRW-1:0] inp_m [ID];
  logic [WRW-1:0] wgt_m [WD];
  logic [ARW-1:0] acc_m [AD];
  int p_dst [UD], p_src [UD], p_wgt [UD];

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    finish_run();
  end

  task automatic chk_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_row(input string req, input logic [ARW-1:0] act, input logic [ARW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [ARW-1:0] mac_ref(input logic [ARW-1:0] a,
      input logic [IRW-1:0] x, input logic [WRW-1:0] w);
    logic [ARW-1:0] r;
    int s;
    for (int b = 0; b < NB; b++)
      for (int o = 0; o < BO; o++) begin
        s = $signed(a[(b*BO+o)*32 +: 32]);
        for (int k = 0; k < BI; k++)
          s += int'($signed(x[(b*BI+k)*8 +: 8])) * int'($signed(w[(o*BI+k)*8 +: 8]));
        r[(b*BO+o)*32 +: 32] = s;
      end
    return r;
  endfunction

  task automatic load_prog(input int base, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      uop_we = 1; uop_wa = UAW'((base + i) % UD);
      uop_wd = {WAW'(p_wgt[i]), IAW'(p_src[i]), AAW'(p_dst[i])};
    end
    @(negedge clk); uop_we = 0;
  endtask

  task automatic read_row(input int a, output logic [ARW-1:0] row);
    @(negedge clk); acc_ra = AAW'(a);
    @(negedge clk); row = acc_rd;
  endtask

  task automatic verify_all(input string req);
    logic [ARW-1:0] row;
    for (int r = 0; r < AD; r++) begin
      read_row(r, row);
      chk_row(req, row, acc_m[r]);
    end
  endtask

  // model keeps the one-behind stale read of adjacent micro-ops
  task automatic apply_model(input int n, input bit clr);
    logic [ARW-1:0] pv, nv;
    int pd;
    pd = -1; pv = '0;
    for (int i = 0; i < n; i++) begin
      nv = clr ? '0 : mac_ref(acc_m[p_dst[i]], inp_m[p_src[i]], wgt_m[p_wgt[i]]);
      if (pd >= 0) acc_m[pd] = pv;
      pd = p_dst[i]; pv = nv;
    end
    if (pd >= 0) acc_m[pd] = pv;
  endtask

  task automatic run_cmd(input int base, input int n, input bit clr, input bit poke);
    int busy_n, haz_n, done_at, done_n, exp_haz;
    busy_n = 0; haz_n = 0; done_at = -1; done_n = 0; exp_haz = 0;
    for (int i = 1; i < n; i++) if (p_dst[i] == p_dst[i-1]) exp_haz++;
    @(negedge clk);
    start = 1; base_r = UAW'(base); count_r = CW'(n); clr_mode = clr;
    @(negedge clk); start = 0;
    for (int k = 0; k < n + 8; k++) begin
      if (busy) busy_n++;
      if (haz) haz_n++;
      if (done) begin done_n++; if (done_at < 0) done_at = k; end
      if (poke && k < 3) begin
        start = 1; base_r = UAW'(20); count_r = CW'(5); clr_mode = 1;
      end else start = 0;
      @(negedge clk);
    end
    start = 0; clr_mode = 0;
    chk_int("R5 busy cycles", busy_n, n);
    chk_int("R6 done latency", done_at, n + 2);
    chk_int("R6 done pulses", done_n, 1);
    chk_int("R8 hazard cycles", haz_n, exp_haz);
    apply_model(n, clr);
  endtask

  initial begin
    logic [ARW-1:0] row;
    logic [WRW-1:0] wr;
    int n, base, d;
    void'($urandom(32'h5eed_1234));

    repeat (3) @(negedge clk);
    chk_int("R10 busy in reset", int'(busy), 0);
    chk_int("R10 done/hazard in reset", int'(done | haz), 0);
    rst_n = 1;
    @(negedge clk);
    chk_int("R10 idle after reset", int'(busy | done | haz), 0);

    // fill input and weight RAMs
    for (int r = 0; r < ID; r++) begin
      if (r == 0) begin
        inp_m[r] = '0; inp_m[r][3*8 +: 8] = 8'sd2;
      end else if (r == 30) inp_m[r] = {(IRW/8){8'h7f}};
      else if (r == 31) inp_m[r] = {(IRW/8){8'h80}};
      else inp_m[r] = {$urandom, $urandom, $urandom, $urandom};
      @(negedge clk); inp_we = 1; inp_wa = IAW'(r); inp_wd = inp_m[r];
    end
    @(negedge clk); inp_we = 0;
    for (int r = 0; r < WD; r++) begin
      if (r == 0) begin
        wr = '0; wr[(5*BI+3)*8 +: 8] = -8'sd3;
      end else if (r == 31) wr = {(WRW/8){8'h80}};
      else for (int j = 0; j < WRW/32; j++) wr[j*32 +: 32] = $urandom;
      wgt_m[r] = wr;
      @(negedge clk); wgt_we = 1; wgt_wa = WAW'(r); wgt_wd = wr;
    end
    @(negedge clk); wgt_we = 0;
    for (int r = 0; r < AD; r++) acc_m[r] = 'x;

    // R4: clear all rows, program wraps the micro-op RAM
    for (int i = 0; i < AD; i++) begin
      p_dst[i] = i; p_src[i] = $urandom % ID; p_wgt[i] = $urandom % WD;
    end
    load_prog(40, AD);
    run_cmd(40, AD, 1'b1, 1'b0);
    verify_all("R4 cleared row");

    // R1/R2: single-element tiles expose field and element positions
    p_dst[0] = 4; p_src[0] = 0; p_wgt[0] = 0;
    load_prog(0, 1);
    run_cmd(0, 1, 1'b0, 1'b0);
    read_row(4, row);
    chk_int("R1 R2 element (0,5)", $signed(row[5*32 +: 32]), -6);
    chk_int("R2 element (0,4)", $signed(row[4*32 +: 32]), 0);

    // R3: extreme operands
    p_dst[0] = 5; p_src[0] = 31; p_wgt[0] = 31;
    p_dst[1] = 6; p_src[1] = 30; p_wgt[1] = 31;
    load_prog(10, 2);
    run_cmd(10, 2, 1'b0, 1'b0);
    read_row(5, row);
    chk_int("R3 -128*-128 sum", $signed(row[0 +: 32]), 262144);
    read_row(6, row);
    chk_int("R3 127*-128 sum", $signed(row[15*32 +: 32]), -260096);

    // R3/R5: random hazard-free programs
    for (int t = 0; t < 6; t++) begin
      n = 1 + ($urandom % 24);
      base = $urandom % UD;
      for (int i = 0; i < n; i++) begin
        do d = $urandom % AD; while (i > 0 && d == p_dst[i-1]);
        p_dst[i] = d; p_src[i] = $urandom % ID; p_wgt[i] = $urandom % WD;
      end
      load_prog(base, n);
      run_cmd(base, n, 1'b0, 1'b0);
      verify_all("R3 random accumulate");
    end

    // R7/R8: adjacent equal destinations lose the first update
    p_dst[0] = 9;  p_src[0] = 1; p_wgt[0] = 2;
    p_dst[1] = 9;  p_src[1] = 3; p_wgt[1] = 4;
    p_dst[2] = 12; p_src[2] = 5; p_wgt[2] = 6;
    p_dst[3] = 9;  p_src[3] = 7; p_wgt[3] = 8;
    p_dst[4] = 12; p_src[4] = 9; p_wgt[4] = 10;
    load_prog(30, 5);
    run_cmd(30, 5, 1'b0, 1'b0);
    verify_all("R7 stale adjacent update");

    // R9: start while busy ignored (a taken poke would clear rows 20..24 region)
    for (int i = 0; i < 5; i++) begin
      p_dst[i] = 20 + i; p_src[i] = i; p_wgt[i] = i;
    end
    load_prog(20, 5);
    for (int i = 0; i < 8; i++) begin
      p_dst[i] = (i % 2) ? 21 : 23; p_src[i] = 10 + i; p_wgt[i] = 11 + i;
    end
    load_prog(0, 8);
    run_cmd(0, 8, 1'b0, 1'b1);
    verify_all("R9 start while busy");

    // R9: zero count ignored
    @(negedge clk); start = 1; count_r = '0; base_r = '0;
    @(negedge clk); start = 0;
    chk_int("R9 zero count busy", int'(busy), 0);
    d = 0;
    for (int k = 0; k < 8; k++) begin
      if (done) d++;
      @(negedge clk);
    end
    chk_int("R9 zero count done", d, 0);
    verify_all("R9 zero count rows");

    finish_run();
  end
endmodule